// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block takes a single-data-rate SDRAM device from power-on to its normal operating state by itself, with no processor driving the command pins. A one-cycle start pulse launches a fixed bring-up order. The block raises the clock enable and waits for the clock to become stable. It then precharges every bank, issues a burst of auto-refresh commands, and loads the mode register. Finally it settles into normal mode and raises a sticky completion flag.

The CAS latency, the chip-select target and the spacing between refresh commands come in as inputs. They are captured on the start pulse. All waits are counted in clock cycles, and a parameter gives the number of cycles in one microsecond. Between commands the block drives NOP on the selected device. Before start it keeps the clock enable low and deselects both devices.

Top module: `sdram_boot_seq`

## Requirements
- R1: While reset is active, and after reset until a start pulse, `sd_cke` is 0, `sd_cs_n` is 2'b11 and `done` is 0. A synchronous reset in the middle of the sequence returns the block to this state on the next cycle.
- R2: `sd_cke` goes high in the cycle after the start pulse is sampled and stays high until reset. The precharge command appears exactly 200*CYC_PER_US cycles after the first cycle with `sd_cke` high.
- R3: The precharge command is encoded as RAS_n=0, CAS_n=1, WE_n=0 with `sd_addr[10]`=1, so that every bank is precharged.
- R4: The following intervals are each 100*CYC_PER_US+1 cycles: precharge to first auto-refresh, last auto-refresh to mode load, and mode load to the first cycle of `done`.
- R5: Exactly 8 auto-refresh commands are issued (RAS_n=0, CAS_n=0, WE_n=1). Consecutive ones are trc_cyc+1 cycles apart, so trc_cyc=0 gives back-to-back commands.
- R6: The mode-register load is encoded as RAS_n=0, CAS_n=0, WE_n=0 with `sd_ba`=0. `sd_addr` carries burst-length code 0 in bits [2:0], 0 in bit 3, the captured CAS latency in bits [6:4] and 0 in all higher bits.
- R7: With `bank_sel`=0 only `sd_cs_n[0]` is driven low (`sd_cs_n`=2'b10). With `bank_sel`=1 only `sd_cs_n[1]` is driven low (2'b01). The other chip select stays high for the whole sequence.
- R8: `done` stays high until the next reset. While it is high, the block drives NOP on the selected device.
- R9: A start pulse while the sequence is running or after it has finished has no effect. Changes to `cas_lat`, `bank_sel` or `trc_cyc` after the start pulse also have no effect.
- R10: In every cycle with `sd_cke` high that carries no command, the pins show NOP: the selected CS_n low, and RAS_n, CAS_n and WE_n high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Pulse that launches the bring-up |
| cas_lat | input | 3 | CAS latency written into the mode word |
| bank_sel | input | 1 | Target device: 0 selects chip select 0, 1 selects chip select 1 |
| trc_cyc | input | 4 | NOP cycles between consecutive auto-refresh commands |
| sd_cke | output | 1 | SDRAM clock enable |
| sd_cs_n | output | 2 | Per-device chip selects, active low |
| sd_ras_n | output | 1 | Row address strobe, active low |
| sd_cas_n | output | 1 | Column address strobe, active low |
| sd_we_n | output | 1 | Write enable, active low |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Address bus |
| done | output | 1 | High once normal mode is reached; sticky |

## Verification
Two things can land in the same cycle. A new start pulse can arrive while a command is on the pins, and new input values can arrive while the sequence is inside a wait. The bench provokes both. During the power-up wait it changes the CAS latency, the chip-select target and the refresh spacing, and it pulses start at the same time. It pulses start again in the cycle right after the precharge, and once more after `done`. Every command the bench logs must still match the values captured at the first start, with the same cycle spacing. The bench also counts every stray chip-select or encoding on the pins. With trc_cyc=0, the last refresh and the entry into the following wait share a cycle boundary, and the fixed interval to the mode load is judged there.

// File: rtl/sdram_boot_pkg.sv
// Shared types for the SDRAM bring-up sequencer.
// Assumes: all users import this package before declaring state or command signals.
package sdram_boot_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_CKE_WAIT,
        ST_PRE,
        ST_PRE_WAIT,
        ST_REF,
        ST_REF_GAP,
        ST_REF_WAIT,
        ST_MRS,
        ST_MRS_WAIT,
        ST_DONE
    } seq_state_t;

    typedef enum logic [2:0] {
        CMD_DESEL,
        CMD_NOP,
        CMD_PRE,
        CMD_REF,
        CMD_MRS
    } sd_cmd_t;

endpackage

// File: rtl/seq_timer.sv
// Up-counter that flags when it reaches a terminal value.
// Assumes: the owner asserts clear in the cycle before a new wait starts, so the
// first cycle of each wait sees a count of zero.
module seq_timer #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clear,
    input  logic [W-1:0] last,
    output logic         hit
);

    logic [W-1:0] cnt;

    // Count cycles, restarting from zero on clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear) cnt <= '0;
        else                 cnt <= cnt + 1'b1;
    end

    // Terminal-count flag.
    always_comb hit = (cnt == last);

endmodule

// File: rtl/seq_cmd_enc.sv
// Maps an abstract command onto the SDRAM command pins.
// Assumes: ADDR_W is at least 11, so that A10 exists, and the CAS field fits in the address bus.
module seq_cmd_enc
    import sdram_boot_pkg::*;
#(
    parameter int NUM_CS = 2,
    parameter int SEL_W  = 1,
    parameter int ADDR_W = 13,
    parameter int BA_W   = 2,
    parameter int CAS_W  = 3
) (
    input  sd_cmd_t            cmd,
    input  logic [SEL_W-1:0]   sel,
    input  logic [CAS_W-1:0]   cas,
    output logic [NUM_CS-1:0]  cs_n,
    output logic               ras_n,
    output logic               cas_n,
    output logic               we_n,
    output logic [BA_W-1:0]    ba,
    output logic [ADDR_W-1:0]  addr
);

    localparam int CAS_LSB = 4;
    localparam int A10     = 10;

    // Chip-select decode: only the chosen device, and only when not deselected.
    always_comb begin
        for (int i = 0; i < NUM_CS; i++) begin
            cs_n[i] = !((cmd != CMD_DESEL) && (sel == SEL_W'(i)));
        end
    end

    // Strobe, bank and address encoding for each command.
    always_comb begin
        ras_n = 1'b1;
        cas_n = 1'b1;
        we_n  = 1'b1;
        ba    = '0;
        addr  = '0;
        unique case (cmd)
            CMD_PRE: begin
                ras_n     = 1'b0;
                we_n      = 1'b0;
                addr[A10] = 1'b1;
            end
            CMD_REF: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
            end
            CMD_MRS: begin
                ras_n = 1'b0;
                cas_n = 1'b0;
                we_n  = 1'b0;
                addr[CAS_LSB +: CAS_W] = cas;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/sdram_boot_seq.sv
// SDRAM power-up sequencer: clock enable, stable-clock wait, precharge-all,
// auto-refresh burst, mode-register load, then normal mode with a sticky done flag.
// Assumes: CYC_PER_US is the number of clk cycles per microsecond, and start is
// only honoured in the idle state, where cas_lat, bank_sel and trc_cyc are captured.
module sdram_boot_seq
    import sdram_boot_pkg::*;
#(
    parameter int CYC_PER_US  = 100,
    parameter int PWRUP_US    = 200,
    parameter int SETTLE_US   = 100,
    parameter int NUM_REFRESH = 8,
    parameter int NUM_CS      = 2,
    parameter int ADDR_W      = 13,
    parameter int BA_W        = 2,
    parameter int CAS_W       = 3,
    parameter int TRC_W       = 4,
    parameter int SEL_W       = (NUM_CS > 1) ? $clog2(NUM_CS) : 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [CAS_W-1:0]   cas_lat,
    input  logic [SEL_W-1:0]   bank_sel,
    input  logic [TRC_W-1:0]   trc_cyc,
    output logic               sd_cke,
    output logic [NUM_CS-1:0]  sd_cs_n,
    output logic               sd_ras_n,
    output logic               sd_cas_n,
    output logic               sd_we_n,
    output logic [BA_W-1:0]    sd_ba,
    output logic [ADDR_W-1:0]  sd_addr,
    output logic               done
);

    localparam int PWR_CYC = PWRUP_US * CYC_PER_US;
    localparam int SET_CYC = SETTLE_US * CYC_PER_US;
    localparam int MAX_CYC = (PWR_CYC > SET_CYC) ? PWR_CYC : SET_CYC;
    localparam int TMR_W   = $clog2(MAX_CYC + 1);
    localparam int REF_W   = (NUM_REFRESH > 1) ? $clog2(NUM_REFRESH) : 1;

    seq_state_t        state, state_nx;
    sd_cmd_t           cmd;
    logic [CAS_W-1:0]  cas_q;
    logic [SEL_W-1:0]  sel_q;
    logic [TRC_W-1:0]  trc_q;
    logic [REF_W-1:0]  ref_cnt;
    logic              ref_last;
    logic [TMR_W-1:0]  tmr_last;
    logic              tmr_hit;
    logic              tmr_clear;

    // State register, capture of the run settings and the refresh counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            cas_q   <= '0;
            sel_q   <= '0;
            trc_q   <= '0;
            ref_cnt <= '0;
        end else begin
            state <= state_nx;
            if (state == ST_IDLE && start) begin
                cas_q <= cas_lat;
                sel_q <= bank_sel;
                trc_q <= trc_cyc;
            end
            if (state == ST_IDLE)     ref_cnt <= '0;
            else if (state == ST_REF) ref_cnt <= ref_cnt + 1'b1;
        end
    end

    always_comb ref_last = (ref_cnt == REF_W'(NUM_REFRESH - 1));

    // Next-state logic for the fixed bring-up order.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start) state_nx = ST_CKE_WAIT;
            ST_CKE_WAIT: if (tmr_hit) state_nx = ST_PRE;
            ST_PRE:      state_nx = ST_PRE_WAIT;
            ST_PRE_WAIT: if (tmr_hit) state_nx = ST_REF;
            ST_REF: begin
                if (ref_last)            state_nx = ST_REF_WAIT;
                else if (trc_q == '0)    state_nx = ST_REF;
                else                     state_nx = ST_REF_GAP;
            end
            ST_REF_GAP:  if (tmr_hit) state_nx = ST_REF;
            ST_REF_WAIT: if (tmr_hit) state_nx = ST_MRS;
            ST_MRS:      state_nx = ST_MRS_WAIT;
            ST_MRS_WAIT: if (tmr_hit) state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_DONE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // Terminal count of the wait that the current state is timing.
    always_comb begin
        unique case (state)
            ST_CKE_WAIT: tmr_last = TMR_W'(PWR_CYC - 1);
            ST_REF_GAP:  tmr_last = TMR_W'(trc_q) - TMR_W'(1);
            default:     tmr_last = TMR_W'(SET_CYC - 1);
        endcase
    end

    always_comb tmr_clear = (state_nx != state);

    seq_timer #(.W(TMR_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (tmr_clear),
        .last  (tmr_last),
        .hit   (tmr_hit)
    );

    // Command chosen by the current state.
    always_comb begin
        unique case (state)
            ST_IDLE: cmd = CMD_DESEL;
            ST_PRE:  cmd = CMD_PRE;
            ST_REF:  cmd = CMD_REF;
            ST_MRS:  cmd = CMD_MRS;
            default: cmd = CMD_NOP;
        endcase
    end

    seq_cmd_enc #(
        .NUM_CS (NUM_CS),
        .SEL_W  (SEL_W),
        .ADDR_W (ADDR_W),
        .BA_W   (BA_W),
        .CAS_W  (CAS_W)
    ) u_enc (
        .cmd   (cmd),
        .sel   (sel_q),
        .cas   (cas_q),
        .cs_n  (sd_cs_n),
        .ras_n (sd_ras_n),
        .cas_n (sd_cas_n),
        .we_n  (sd_we_n),
        .ba    (sd_ba),
        .addr  (sd_addr)
    );

    // Clock enable and completion flag.
    always_comb begin
        sd_cke = (state != ST_IDLE);
        done   = (state == ST_DONE);
    end

endmodule

// File: rtl/sdram_boot_seq_chk.sv
// Property checker for the SDRAM bring-up sequencer, bound to every instance.
// Assumes: it sees only the top-level pins; it keeps its own refresh tally.
module sdram_boot_seq_chk #(
    parameter int NUM_CS      = 2,
    parameter int ADDR_W      = 13,
    parameter int BA_W        = 2,
    parameter int NUM_REFRESH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sd_cke,
    input logic [NUM_CS-1:0] sd_cs_n,
    input logic              sd_ras_n,
    input logic              sd_cas_n,
    input logic              sd_we_n,
    input logic [BA_W-1:0]   sd_ba,
    input logic [ADDR_W-1:0] sd_addr,
    input logic              done
);

    logic sel, is_pre, is_ref, is_mrs;
    int   ref_seen;

    // Decode of the pins into command kinds.
    always_comb begin
        sel    = ~&sd_cs_n;
        is_pre = sel && !sd_ras_n &&  sd_cas_n && !sd_we_n;
        is_ref = sel && !sd_ras_n && !sd_cas_n &&  sd_we_n;
        is_mrs = sel && !sd_ras_n && !sd_cas_n && !sd_we_n;
    end

    // Independent tally of refresh commands since reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      ref_seen <= 0;
        else if (is_ref) ref_seen <= ref_seen + 1;
    end

    a_r1_idle_deselect: assert property (@(posedge clk) disable iff (!rst_n)
        !sd_cke |-> (&sd_cs_n));

    a_r2_cke_holds: assert property (@(posedge clk) disable iff (!rst_n)
        sd_cke |=> sd_cke);

    a_r3_pre_all_banks: assert property (@(posedge clk) disable iff (!rst_n)
        is_pre |-> sd_addr[10]);

    a_r5_refresh_limit: assert property (@(posedge clk) disable iff (!rst_n)
        ref_seen <= NUM_REFRESH);

    a_r5_refresh_before_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ref_seen == NUM_REFRESH));

    a_r6_mode_low_bits: assert property (@(posedge clk) disable iff (!rst_n)
        is_mrs |-> (sd_addr[3:0] == 4'd0 && sd_ba == '0));

    a_r7_single_cs: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~sd_cs_n) <= 1);

    a_r8_done_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> done);

    a_r8_done_is_nop: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (sd_cke && sel && sd_ras_n && sd_cas_n && sd_we_n));

endmodule

bind sdram_boot_seq sdram_boot_seq_chk #(
    .NUM_CS      (NUM_CS),
    .ADDR_W      (ADDR_W),
    .BA_W        (BA_W),
    .NUM_REFRESH (NUM_REFRESH)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .sd_cke   (sd_cke),
    .sd_cs_n  (sd_cs_n),
    .sd_ras_n (sd_ras_n),
    .sd_cas_n (sd_cas_n),
    .sd_we_n  (sd_we_n),
    .sd_ba    (sd_ba),
    .sd_addr  (sd_addr),
    .done     (done)
);

// File: tb/sim_sdram_boot_seq.sv
module sim_sdram_boot_seq;

    localparam int CPU  = 2;
    localparam int NPWR = 200 * CPU;
    localparam int NSET = 100 * CPU;

    // Command kinds seen on the pins
    localparam int K_PRE = 1;
    localparam int K_REF = 2;
    localparam int K_MRS = 3;

    // Vectors: {cas_lat[2:0], bank_sel, trc_cyc[3:0]}
    localparam logic [7:0] VEC [4] = '{
        {3'd2, 1'b0, 4'd3},
        {3'd3, 1'b1, 4'd0},
        {3'd1, 1'b0, 4'd1},
        {3'd7, 1'b1, 4'd15}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [2:0]  cas_lat = 3'd0;
    logic        bank_sel = 1'b0;
    logic [3:0]  trc_cyc = 4'd0;
    logic        sd_cke;
    logic [1:0]  sd_cs_n;
    logic        sd_ras_n, sd_cas_n, sd_we_n;
    logic [1:0]  sd_ba;
    logic [12:0] sd_addr;
    logic        done;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    sdram_boot_seq #(.CYC_PER_US(CPU)) u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .cas_lat  (cas_lat),
        .bank_sel (bank_sel),
        .trc_cyc  (trc_cyc),
        .sd_cke   (sd_cke),
        .sd_cs_n  (sd_cs_n),
        .sd_ras_n (sd_ras_n),
        .sd_cas_n (sd_cas_n),
        .sd_we_n  (sd_we_n),
        .sd_ba    (sd_ba),
        .sd_addr  (sd_addr),
        .done     (done)
    );

    always #10 clk = ~clk;

    // Pin monitor, sampled on the falling edge
    int   cyc = 0;
    bit   logging = 1'b0;
    logic [1:0] exp_cs = 2'b10;
    int   ncmd, cke_rise, done_rise, start_cyc, pin_bad;
    int   k_kind [16];
    int   k_cyc  [16];
    int   k_addr [16];
    int   k_ba   [16];

    always @(negedge clk) begin
        if (logging) begin
            if (start && start_cyc < 0) start_cyc = cyc;
            if (sd_cke && cke_rise < 0) cke_rise = cyc;
            if (done && done_rise < 0)  done_rise = cyc;
            if (sd_cke) begin
                if (sd_cs_n != exp_cs) pin_bad++;
                else begin
                    int kind;
                    case ({sd_ras_n, sd_cas_n, sd_we_n})
                        3'b111: kind = 0;
                        3'b010: kind = K_PRE;
                        3'b001: kind = K_REF;
                        3'b000: kind = K_MRS;
                        default: begin kind = -1; pin_bad++; end
                    endcase
                    if (kind > 0) begin
                        if (ncmd < 16) begin
                            k_kind[ncmd] = kind;
                            k_cyc[ncmd]  = cyc;
                            k_addr[ncmd] = int'(sd_addr);
                            k_ba[ncmd]   = int'(sd_ba);
                        end
                        ncmd++;
                    end
                end
            end else if (sd_cs_n != 2'b11) pin_bad++;
        end
        cyc++;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic drive_cycle();
        @(posedge clk);
        #5;
    endtask

    task automatic clear_log();
        ncmd = 0; cke_rise = -1; done_rise = -1; start_cyc = -1; pin_bad = 0;
        for (int i = 0; i < 16; i++) begin
            k_kind[i] = 0; k_cyc[i] = 0; k_addr[i] = 0; k_ba[i] = 0;
        end
    endtask

    task automatic run_vec(input logic [2:0] c, input logic b, input logic [3:0] t);
        int gap_bad;
        drive_cycle();
        rst_n = 1'b0; start = 1'b0;
        cas_lat = c; bank_sel = b; trc_cyc = t;
        exp_cs = b ? 2'b01 : 2'b10;
        repeat (3) drive_cycle();
        rst_n = 1'b1;
        clear_log();
        logging = 1'b1;
        drive_cycle();
        start = 1'b1;
        drive_cycle();
        start = 1'b0;
        // R9: change every input and pulse start during the power-up wait
        repeat (100) drive_cycle();
        cas_lat = ~c; bank_sel = ~b; trc_cyc = t ^ 4'h5; start = 1'b1;
        drive_cycle();
        start = 1'b0;
        // R9: pulse start right after the precharge
        while (ncmd < 1) drive_cycle();
        start = 1'b1;
        drive_cycle();
        start = 1'b0;
        while (!done) drive_cycle();
        repeat (20) drive_cycle();
        start = 1'b1;
        drive_cycle();
        start = 1'b0;
        repeat (40) drive_cycle();

        check(cke_rise == start_cyc + 1, "R2 cke rise", cke_rise, start_cyc + 1);
        check(k_kind[0] == K_PRE, "R3 first command is precharge", k_kind[0], K_PRE);
        check(k_cyc[0] - cke_rise == NPWR, "R2 power-up wait", k_cyc[0] - cke_rise, NPWR);
        check(k_addr[0][10] == 1'b1, "R3 precharge A10", k_addr[0], 1024);
        check(k_cyc[1] - k_cyc[0] == NSET + 1, "R4 precharge to refresh", k_cyc[1] - k_cyc[0], NSET + 1);
        gap_bad = 0;
        for (int i = 1; i <= 8; i++) begin
            if (k_kind[i] != K_REF) gap_bad++;
            if (i > 1 && k_cyc[i] - k_cyc[i-1] != int'(t) + 1) gap_bad++;
        end
        check(gap_bad == 0, "R5 refresh kinds and spacing", gap_bad, 0);
        check(ncmd == 10, "R5 R9 command count incl. ignored starts", ncmd, 10);
        check(k_kind[9] == K_MRS, "R6 mode load kind", k_kind[9], K_MRS);
        check(k_cyc[9] - k_cyc[8] == NSET + 1, "R4 refresh to mode load", k_cyc[9] - k_cyc[8], NSET + 1);
        check(k_addr[9] == int'(c) << 4, "R6 R9 mode word", k_addr[9], int'(c) << 4);
        check(k_ba[9] == 0, "R6 mode bank address", k_ba[9], 0);
        check(done_rise - k_cyc[9] == NSET + 1, "R4 mode load to done", done_rise - k_cyc[9], NSET + 1);
        check(pin_bad == 0, "R7 R10 chip select and NOP encoding", pin_bad, 0);
        check(done == 1'b1, "R8 done sticky after late start", int'(done), 1);
        logging = 1'b0;
    endtask

    initial begin
        #(20ns * 150000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) drive_cycle();
        check(sd_cke == 1'b0, "R1 cke in reset", int'(sd_cke), 0);
        check(sd_cs_n == 2'b11, "R1 cs in reset", int'(sd_cs_n), 3);
        check(done == 1'b0, "R1 done in reset", int'(done), 0);
        rst_n = 1'b1;
        repeat (20) drive_cycle();
        check(sd_cke == 1'b0 && sd_cs_n == 2'b11 && done == 1'b0,
              "R1 idle without start", int'({sd_cke, sd_cs_n, done}), 6);

        for (int v = 0; v < 4; v++) begin
            run_vec(VEC[v][7:5], VEC[v][4], VEC[v][3:0]);
        end

        // R1: reset in the middle of the refresh burst
        drive_cycle();
        rst_n = 1'b0;
        cas_lat = 3'd2; bank_sel = 1'b0; trc_cyc = 4'd2; exp_cs = 2'b10;
        drive_cycle();
        rst_n = 1'b1;
        clear_log();
        logging = 1'b1;
        start = 1'b1;
        drive_cycle();
        start = 1'b0;
        while (ncmd < 4) drive_cycle();
        rst_n = 1'b0;
        drive_cycle();
        check(sd_cke == 1'b0 && sd_cs_n == 2'b11 && done == 1'b0,
              "R1 mid-sequence reset", int'({sd_cke, sd_cs_n, done}), 6);
        rst_n = 1'b1;
        logging = 1'b0;
        repeat (5) drive_cycle();
        check(sd_cke == 1'b0, "R1 stays idle after mid reset", int'(sd_cke), 0);

        finished = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule